// File: doc/BRIEF.md
# Strip Sensor Zero-Suppression Pipeline

This block thins out raw readout from a silicon strip sensor before the data go further downstream. Every trigger, one sensor delivers 96 ADC beats: 32 strips, each sampled in three consecutive time slots. Each beat carries a sensor id, a strip index, a slot index and a 12-bit unsigned ADC code. The block removes a per-strip pedestal and applies a per-strip gain as each beat arrives, and stores the corrected value. It also accumulates a running sum for each time slot.

When the closing beat of a sensor arrives, the block stops accepting input. It then scans the 32 stored strips, one strip per cycle. For each strip it subtracts the slot's common-mode value (the mean over the sensor) from each sample. It keeps the strip only if the middle sample forms a peak and lies above a programmable threshold. Each surviving strip leaves as one output word that carries the sensor id, the strip index and the three cleaned samples.

Detector occupancy is low, so only a few percent of strips survive, and the output volume is far smaller than the input. A simple write port loads the pedestal table, the gain table and the threshold.

Top module: `zs_pipeline`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. Every pedestal reads 0, every gain reads 256 (unity) and the threshold is 0.
- R2: An accepted beat is corrected to clamp16(((adc - ped[strip]) * gain[strip]) >>> 8). The gain is an unsigned 12-bit value with 8 fractional bits, the pedestal is 12 bits, and clamp16 saturates to the signed 16-bit range.
- R3: For each slot, the common-mode value is the sum of that slot's 32 corrected values, shifted right arithmetically by 5. Every strip's sample in that slot becomes clamp16(corrected - common mode).
- R4: A strip counts as a bunch-crossing candidate only when its cleaned slot-1 sample is greater than or equal to both its slot-0 sample and its slot-2 sample. Ties count as a peak.
- R5: A candidate is emitted only when its cleaned slot-1 sample is strictly greater than the signed threshold. A sample equal to the threshold is dropped.
- R6: An output word carries the sensor id of the closing beat, the 5-bit strip index and the cleaned samples of slots 0, 1 and 2 on `out_s0`, `out_s1` and `out_s2`. Words leave in ascending strip order, one cycle each, and at most once per strip.
- R7: A sensor closes on the accepted beat with strip 31 and slot 2. The beats before it may come in any order, but each (strip, slot) pair appears exactly once. `in_ready` is low for exactly the 32 cycles after the closing edge. The word for strip k appears k+1 cycles after that edge.
- R8: A beat presented while `in_ready` is low is not taken. It changes neither the stored data nor the sums, and it does not restart the scan.
- R9: A write with `cfg_we` high stores `cfg_wdata` at the clock edge. `cfg_sel` 0 writes the pedestal of strip `cfg_idx` from the low 12 bits. `cfg_sel` 1 writes that strip's gain from the low 12 bits. `cfg_sel` 2 writes the 16-bit signed threshold. The new value applies to beats accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Target: 0 pedestal, 1 gain, 2 threshold |
| cfg_idx | input | 5 | Strip index for pedestal and gain writes |
| cfg_wdata | input | 16 | Write data |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat accepted when high together with `in_valid` |
| in_sid | input | 4 | Sensor id |
| in_strip | input | 5 | Strip index |
| in_slot | input | 2 | Time slot, 0 to 2 |
| in_adc | input | 12 | Unsigned ADC code |
| out_valid | output | 1 | Surviving strip word present |
| out_sid | output | 4 | Sensor id of the word |
| out_strip | output | 5 | Strip index of the word |
| out_s0 | output | 16 | Cleaned slot-0 sample, signed |
| out_s1 | output | 16 | Cleaned slot-1 sample, signed |
| out_s2 | output | 16 | Cleaned slot-2 sample, signed |

## Verification
The assertions assume that every sensor supplies each strip and slot pair exactly once and ends on the strip 31, slot 2 beat. They also assume that the threshold does not change while a scan runs, and the threshold check compares against the previous cycle's value on that basis. The stimulus drives whole sensors in strip-major or slot-major order and makes its table writes only while the block is idle. It also holds a stray closing beat on the input through one scan, so that the stall path is exercised without breaking the one-beat-per-pair rule for accepted beats.

// File: rtl/zs_pkg.sv
package zs_pkg;

  typedef enum logic {ST_FILL, ST_DRAIN} zs_state_e;

  localparam logic [1:0] SEL_PED  = 2'd0;
  localparam logic [1:0] SEL_GAIN = 2'd1;
  localparam logic [1:0] SEL_THR  = 2'd2;

  // saturate a signed value into a w-bit signed range
  function automatic logic signed [31:0] zs_clamp(input logic signed [31:0] v,
                                                  input int unsigned w);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = (32'sd1 <<< (w - 1)) - 32'sd1;
    lo = -hi - 32'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/zs_calib.sv
module zs_calib #(
  parameter int ADC_W     = 12,
  parameter int SMP_W     = 16,
  parameter int NSTRIP    = 32,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 8,
  localparam int IDX_W    = $clog2(NSTRIP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SMP_W-1:0] cfg_wdata,
  input  logic [ADC_W-1:0] smp_adc,
  input  logic [IDX_W-1:0] smp_strip,
  output logic [SMP_W-1:0] thr_o,
  output logic [SMP_W-1:0] corr_o
);
  import zs_pkg::*;

  logic [ADC_W-1:0]  ped_q  [NSTRIP];
  logic [ADC_W-1:0]  ped_d  [NSTRIP];
  logic [GAIN_W-1:0] gain_q [NSTRIP];
  logic [GAIN_W-1:0] gain_d [NSTRIP];
  logic [SMP_W-1:0]  thr_q, thr_d;

  always_comb begin
    ped_d  = ped_q;
    gain_d = gain_q;
    thr_d  = thr_q;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_PED:  ped_d[cfg_idx]  = cfg_wdata[ADC_W-1:0];
        SEL_GAIN: gain_d[cfg_idx] = cfg_wdata[GAIN_W-1:0];
        SEL_THR:  thr_d           = cfg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTRIP; i++) begin
        ped_q[i]  <= '0;
        gain_q[i] <= GAIN_W'(1 << GAIN_FRAC);
      end
      thr_q <= '0;
    end else begin
      ped_q  <= ped_d;
      gain_q <= gain_d;
      thr_q  <= thr_d;
    end
  end

  int diff, prod;
  always_comb begin
    diff   = int'(smp_adc) - int'(ped_q[smp_strip]);
    prod   = diff * int'(gain_q[smp_strip]);
    corr_o = SMP_W'(zs_clamp(prod >>> GAIN_FRAC, SMP_W));
  end

  assign thr_o = thr_q;

endmodule

// File: rtl/zs_sensor_buf.sv
module zs_sensor_buf #(
  parameter int SMP_W  = 16,
  parameter int NSTRIP = 32,
  parameter int NSLOT  = 3,
  localparam int IDX_W  = $clog2(NSTRIP),
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int SUM_W  = SMP_W + IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_strip,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic [SMP_W-1:0]       wr_val,
  input  logic                   sum_clr,
  input  logic [IDX_W-1:0]       rd_strip,
  output logic [NSLOT*SMP_W-1:0] rd_vals,
  output logic [NSLOT*SMP_W-1:0] cm_vals
);

  logic [SMP_W-1:0] mem_q [NSTRIP][NSLOT];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_slot < SLOT_W'(NSLOT))) mem_q[wr_strip][wr_slot] <= wr_val;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic signed [SUM_W-1:0] sum_q, sum_d;

    always_comb begin
      sum_d = sum_q;
      if (sum_clr) sum_d = '0;
      else if (wr_en && (wr_slot == SLOT_W'(g)))
        sum_d = sum_q + SUM_W'($signed(wr_val));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_d;
    end

    // mean over the sensor: divide by the strip count with an arithmetic shift
    assign cm_vals[g*SMP_W +: SMP_W] = SMP_W'(sum_q >>> IDX_W);
    assign rd_vals[g*SMP_W +: SMP_W] = mem_q[rd_strip][g];
  end

endmodule

// File: rtl/zs_select.sv
module zs_select #(
  parameter int SMP_W  = 16,
  parameter int NSTRIP = 32,
  parameter int NSLOT  = 3,
  parameter int SID_W  = 4,
  localparam int IDX_W = $clog2(NSTRIP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_en,
  input  logic [IDX_W-1:0]       scan_strip,
  input  logic [SID_W-1:0]       sid,
  input  logic [SMP_W-1:0]       thr,
  input  logic [NSLOT*SMP_W-1:0] rd_vals,
  input  logic [NSLOT*SMP_W-1:0] cm_vals,
  output logic                   out_valid,
  output logic [SID_W-1:0]       out_sid,
  output logic [IDX_W-1:0]       out_strip,
  output logic [SMP_W-1:0]       out_s0,
  output logic [SMP_W-1:0]       out_s1,
  output logic [SMP_W-1:0]       out_s2
);
  import zs_pkg::*;

  logic signed [SMP_W-1:0] cln [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_cm
    always_comb
      cln[g] = SMP_W'(zs_clamp(int'($signed(rd_vals[g*SMP_W +: SMP_W]))
                             - int'($signed(cm_vals[g*SMP_W +: SMP_W])), SMP_W));
  end

  logic peak, hit;
  assign peak = (cln[1] >= cln[0]) && (cln[1] >= cln[2]);
  assign hit  = scan_en && peak && (cln[1] > $signed(thr));

  logic             vld_d;
  logic [SID_W-1:0] sid_d;
  logic [IDX_W-1:0] strip_d;
  logic [SMP_W-1:0] s0_d, s1_d, s2_d;

  always_comb begin
    vld_d   = hit;
    sid_d   = out_sid;
    strip_d = out_strip;
    s0_d    = out_s0;
    s1_d    = out_s1;
    s2_d    = out_s2;
    if (hit) begin
      sid_d   = sid;
      strip_d = scan_strip;
      s0_d    = cln[0];
      s1_d    = cln[1];
      s2_d    = cln[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sid   <= '0;
      out_strip <= '0;
      out_s0    <= '0;
      out_s1    <= '0;
      out_s2    <= '0;
    end else begin
      out_valid <= vld_d;
      out_sid   <= sid_d;
      out_strip <= strip_d;
      out_s0    <= s0_d;
      out_s1    <= s1_d;
      out_s2    <= s2_d;
    end
  end

  // R4: an emitted word always shows a middle-sample peak
  p_peak_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_s1) >= $signed(out_s0)) && ($signed(out_s1) >= $signed(out_s2)));

  // R5: an emitted middle sample lies strictly above the threshold in force
  p_above_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $signed(out_s1) > $signed($past(thr)));

  // R6: back-to-back words carry consecutive strip indices
  p_strip_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_strip == $past(out_strip) + 1'b1);

endmodule

// File: rtl/zs_pipeline.sv
module zs_pipeline #(
  parameter int ADC_W     = 12,
  parameter int SMP_W     = 16,
  parameter int NSTRIP    = 32,
  parameter int NSLOT     = 3,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 8,
  parameter int SID_W     = 4,
  localparam int IDX_W    = $clog2(NSTRIP),
  localparam int SLOT_W   = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SMP_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SID_W-1:0]  in_sid,
  input  logic [IDX_W-1:0]  in_strip,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [ADC_W-1:0]  in_adc,
  output logic              out_valid,
  output logic [SID_W-1:0]  out_sid,
  output logic [IDX_W-1:0]  out_strip,
  output logic [SMP_W-1:0]  out_s0,
  output logic [SMP_W-1:0]  out_s1,
  output logic [SMP_W-1:0]  out_s2
);
  import zs_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {srst_n, rst_meta} <= 2'b00;
    else        {srst_n, rst_meta} <= {rst_meta, 1'b1};
  end

  zs_state_e        state_q, state_d;
  logic [IDX_W-1:0] scan_q, scan_d;
  logic [SID_W-1:0] sid_q, sid_d;
  logic             accept, close_beat, scan_end;

  assign in_ready   = (state_q == ST_FILL);
  assign accept     = in_valid && in_ready;
  assign close_beat = accept && (in_strip == IDX_W'(NSTRIP - 1)) && (in_slot == SLOT_W'(NSLOT - 1));
  assign scan_end   = (state_q == ST_DRAIN) && (scan_q == IDX_W'(NSTRIP - 1));

  always_comb begin
    state_d = state_q;
    scan_d  = scan_q;
    sid_d   = accept ? in_sid : sid_q;
    if (state_q == ST_FILL) begin
      if (close_beat) begin
        state_d = ST_DRAIN;
        scan_d  = '0;
      end
    end else begin
      scan_d = scan_q + 1'b1;
      if (scan_end) state_d = ST_FILL;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_FILL;
      scan_q  <= '0;
      sid_q   <= '0;
    end else begin
      state_q <= state_d;
      scan_q  <= scan_d;
      sid_q   <= sid_d;
    end
  end

  logic [SMP_W-1:0]       thr, corr;
  logic [NSLOT*SMP_W-1:0] rd_vals, cm_vals;

  zs_calib #(
    .ADC_W(ADC_W), .SMP_W(SMP_W), .NSTRIP(NSTRIP), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_calib (
    .clk(clk), .rst_n(srst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .smp_adc(in_adc), .smp_strip(in_strip), .thr_o(thr), .corr_o(corr)
  );

  zs_sensor_buf #(
    .SMP_W(SMP_W), .NSTRIP(NSTRIP), .NSLOT(NSLOT)
  ) u_buf (
    .clk(clk), .rst_n(srst_n), .wr_en(accept), .wr_strip(in_strip), .wr_slot(in_slot),
    .wr_val(corr), .sum_clr(scan_end), .rd_strip(scan_q), .rd_vals(rd_vals), .cm_vals(cm_vals)
  );

  zs_select #(
    .SMP_W(SMP_W), .NSTRIP(NSTRIP), .NSLOT(NSLOT), .SID_W(SID_W)
  ) u_sel (
    .clk(clk), .rst_n(srst_n), .scan_en(state_q == ST_DRAIN), .scan_strip(scan_q),
    .sid(sid_q), .thr(thr), .rd_vals(rd_vals), .cm_vals(cm_vals),
    .out_valid(out_valid), .out_sid(out_sid), .out_strip(out_strip),
    .out_s0(out_s0), .out_s1(out_s1), .out_s2(out_s2)
  );

  // R7: the closing beat stalls the input on the next cycle
  p_close_stall_r7: assert property (@(posedge clk) disable iff (!srst_n)
    close_beat |=> !in_ready);

  // R7: words appear only as the result of a scan cycle, never while filling
  p_emit_after_drain_r7: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> !$past(in_ready));

endmodule

// File: tb/zs_pipeline_tb.sv
module zs_pipeline_tb;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [4:0]  cfg_idx;
  logic [15:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_sid;
  logic [4:0]  in_strip;
  logic [1:0]  in_slot;
  logic [11:0] in_adc;
  logic        out_valid;
  logic [3:0]  out_sid;
  logic [4:0]  out_strip;
  logic [15:0] out_s0, out_s1, out_s2;

  always #5 clk = ~clk;

  zs_pipeline u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_sid(in_sid),
    .in_strip(in_strip), .in_slot(in_slot), .in_adc(in_adc), .out_valid(out_valid),
    .out_sid(out_sid), .out_strip(out_strip), .out_s0(out_s0), .out_s1(out_s1), .out_s2(out_s2)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // behavioural model state
  int ped_m[NS], gain_m[NS], thr_m;
  int corr_m[NS][3], res_m[NS][3];
  bit keep_m[NS];
  bit drn = 0, acc = 0, chk_en = 0;
  int didx = 0, sid_cur = 0, sid_lat = 0;
  int adc_v[NS][3];
  int obs_strip[$], obs_s1[$];

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic close_sensor();
    for (int s = 0; s < 3; s++) begin
      int sum = 0;
      for (int i = 0; i < NS; i++) sum += corr_m[i][s];
      for (int i = 0; i < NS; i++) res_m[i][s] = sat16(corr_m[i][s] - (sum >>> 5));
    end
    for (int i = 0; i < NS; i++)
      keep_m[i] = (res_m[i][1] >= res_m[i][0]) && (res_m[i][1] >= res_m[i][2]) && (res_m[i][1] > thr_m);
  endtask

  // one clock: advance the model over the edge just passed, then compare
  task automatic tick();
    bit ev = 0;
    int k = 0;
    @(negedge clk);
    acc = 0;
    if (drn) begin
      k = didx;
      ev = keep_m[k];
      didx++;
      if (didx == NS) drn = 0;
    end else if (in_valid) begin
      acc = 1;
      corr_m[in_strip][in_slot] = sat16(((int'(in_adc) - ped_m[in_strip]) * gain_m[in_strip]) >>> 8);
      sid_cur = in_sid;
      if (in_strip == 5'd31 && in_slot == 2'd2) begin
        close_sensor();
        sid_lat = sid_cur;
        drn = 1;
        didx = 0;
      end
    end
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: ped_m[cfg_idx]  = int'(cfg_wdata[11:0]);
        2'd1: gain_m[cfg_idx] = int'(cfg_wdata[11:0]);
        2'd2: thr_m = int'($signed(cfg_wdata));
        default: ;
      endcase
    end
    if (chk_en) begin
      // R7 R8: stall window
      check(in_ready == !drn, "R7 in_ready", int'(in_ready), int'(!drn));
      check(out_valid == ev, "R5 out_valid", int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        check(out_strip == k[4:0] && out_sid == sid_lat[3:0], "R6 strip/sid",
              int'(out_strip) * 16 + int'(out_sid), k * 16 + sid_lat);
        check(int'($signed(out_s0)) == res_m[k][0], "R3 s0", int'($signed(out_s0)), res_m[k][0]);
        check(int'($signed(out_s1)) == res_m[k][1], "R3 s1", int'($signed(out_s1)), res_m[k][1]);
        check(int'($signed(out_s2)) == res_m[k][2], "R3 s2", int'($signed(out_s2)), res_m[k][2]);
      end
    end
    if (out_valid) begin
      obs_strip.push_back(int'(out_strip));
      obs_s1.push_back(int'($signed(out_s1)));
    end
  endtask

  task automatic cfg(int sel, int idx, int data);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 5'(idx); cfg_wdata = 16'(data);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic send_sensor(int sid, bit slot_major, bit junk);
    for (int a = 0; a < 3 * NS; a++) begin
      int st = slot_major ? (a % NS) : (a / 3);
      int sl = slot_major ? (a / NS) : (a % 3);
      in_valid = 1'b1; in_sid = 4'(sid); in_strip = 5'(st); in_slot = 2'(sl);
      in_adc = 12'(adc_v[st][sl]);
      do tick(); while (!acc);
    end
    if (junk) begin
      // R8: a stray closing beat held during the scan must be ignored
      in_valid = 1'b1; in_sid = 4'(sid + 1); in_strip = 5'd31; in_slot = 2'd2; in_adc = 12'd3000;
      while (drn) tick();
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (drn) tick();
    tick();
  endtask

  task automatic fill(int v);
    for (int i = 0; i < NS; i++) for (int s = 0; s < 3; s++) adc_v[i][s] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin ped_m[i] = 0; gain_m[i] = 256; end
    thr_m = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_sid = '0; in_strip = '0; in_slot = '0; in_adc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();
    tag = "R1";
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk_en = 1;

    // R1 R3: default tables, single peak on strip 5
    tag = "R1 R3";
    fill(100);
    adc_v[5][1] = 400; adc_v[5][2] = 200;
    obs_strip.delete(); obs_s1.delete();
    send_sensor(3, 0, 0);
    wait_idle();
    check(obs_strip.size() == 1, "R3 word count", obs_strip.size(), 1);
    if (obs_strip.size() == 1) begin
      check(obs_strip[0] == 5, "R6 strip", obs_strip[0], 5);
      check(obs_s1[0] == 291, "R3 common mode result", obs_s1[0], 291);
    end

    // R9 R2 R7: table writes, slot-major order
    tag = "R9 R2";
    cfg(0, 3, 50); cfg(1, 3, 512); cfg(2, 0, 20);
    fill(60);
    adc_v[3][1] = 200; adc_v[3][2] = 100;
    obs_strip.delete(); obs_s1.delete();
    send_sensor(7, 1, 0);
    wait_idle();
    check(obs_s1.size() == 1 && obs_s1[0] == 233, "R9 written tables",
          obs_s1.size() ? obs_s1[0] : -1, 233);

    // R4: ties count as peaks; rising tail is rejected
    tag = "R4";
    cfg(0, 3, 0); cfg(1, 3, 256); cfg(2, 0, 53);
    fill(0);
    adc_v[4][1] = 64; adc_v[4][2] = 64;
    adc_v[6][0] = 64; adc_v[6][1] = 64;
    adc_v[8][1] = 64; adc_v[8][2] = 96;
    adc_v[10][1] = 70;
    adc_v[20][0] = 256; adc_v[20][1] = 58; adc_v[20][2] = 160;
    obs_strip.delete(); obs_s1.delete();
    send_sensor(9, 0, 0);
    wait_idle();
    check(obs_strip.size() == 3, "R4 tie survivors", obs_strip.size(), 3);
    if (obs_strip.size() == 3)
      check(obs_strip[0] == 4 && obs_strip[1] == 6 && obs_strip[2] == 10, "R6 order",
            obs_strip[0] * 10000 + obs_strip[1] * 100 + obs_strip[2], 40610);

    // R5: sample equal to threshold is dropped
    tag = "R5";
    cfg(2, 0, 54);
    obs_strip.delete(); obs_s1.delete();
    send_sensor(10, 0, 0);
    wait_idle();
    check(obs_strip.size() == 1 && obs_strip[0] == 10, "R5 equality dropped",
          obs_strip.size(), 1);

    // R2 R3: saturation both ways
    tag = "R2";
    cfg(2, 0, 0); cfg(1, 7, 4095); cfg(0, 9, 4095); cfg(1, 9, 4095);
    fill(0);
    adc_v[7][1] = 4095;
    obs_strip.delete(); obs_s1.delete();
    send_sensor(12, 0, 0);
    wait_idle();
    check(obs_strip.size() == 1 && obs_s1[0] == 32767, "R2 saturated peak",
          obs_s1.size() ? obs_s1[0] : -1, 32767);

    // R8: stray beat during scan, then back-to-back sensors
    tag = "R8";
    cfg(1, 7, 256); cfg(0, 9, 0); cfg(1, 9, 256); cfg(2, 0, 30);
    for (int i = 0; i < NS; i++) for (int s = 0; s < 3; s++) adc_v[i][s] = 200 + $urandom_range(0, 20);
    adc_v[12][1] = 900; adc_v[25][1] = 700; adc_v[25][0] = 400;
    send_sensor(1, 0, 1);
    send_sensor(2, 1, 0);
    wait_idle();

    // R2 R3 R4 R5 R6: randomized tables and data
    tag = "R6 random";
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NS; i++) begin
        cfg(0, i, $urandom_range(50, 300));
        cfg(1, i, $urandom_range(180, 340));
      end
      cfg(2, 0, $urandom_range(0, 120));
      for (int i = 0; i < NS; i++) for (int s = 0; s < 3; s++) adc_v[i][s] = $urandom_range(150, 350);
      for (int h = 0; h < 3; h++) adc_v[$urandom_range(0, NS - 1)][1] = $urandom_range(600, 4095);
      send_sensor(r + 4, r[0], r[1]);
      wait_idle();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule